// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block turns a stream of stereo PCM samples into a consumer digital-audio bitstream on one output line. It runs from a single transmit clock at twice the line bit rate, which is 128 ticks per stereo sample. Each stereo sample becomes a frame of two 32-slot subframes, left first. A subframe holds a synchronisation pattern, a 24-bit audio word sent least significant bit first, the validity and user flags, one channel-status bit and an even-parity bit. The line is biphase-mark coded. The synchronisation patterns deliberately break that code so that a receiver can find the subframe boundaries.

A producer offers a sample with `s_valid`. The block takes it on the single cycle of each frame in which `s_ready` is high. If no sample is offered at that moment, the frame carries silence. A free-running consumed-sample count and a one-cycle pulse per taken sample tell the producer when to refill its buffers. The channel-status sequence runs over blocks of 192 frames and carries the sample-rate code chosen by `rate_sel`. Transmit clocks of 4.096, 5.6448 and 6.144 MHz give 32, 44.1 and 48 kHz sample rates.

Top module: `bmc_audio_tx`

## Requirements
- R1: While `rst` is held, `line_out` is 0, `consumed` is 0, `take_pulse` is 0 and `s_ready` is 1. The half-cell that follows the first clock edge after reset is released is the first half-cell of frame 0 of a block.
- R2: A frame is 128 clock cycles long. `s_ready` is high in exactly one cycle of each frame, the last one, and a sample offered in that cycle is carried by the frame that starts at the next edge.
- R3: Slots 4 to 31 use biphase-mark coding. Each cell is two clock cycles. The line always changes level at the start of a cell and changes again at mid-cell only when the bit is 1.
- R4: Slots 0 to 3 carry an 8-half-cell sync pattern, written first half-cell first for a line that stood at 0 beforehand. The patterns are 11101000 for the left subframe of frame 0 of each 192-frame block, 11100010 for every other left subframe and 11100100 for every right subframe. The pattern is inverted when the line stood at 1.
- R5: With `use16`=0, slot 4+k carries bit k of the 24-bit sample, for k from 0 to 23.
- R6: With `use16`=1, slots 4 to 11 are 0 and slot 12+k carries bit k of the sample, for k from 0 to 15. Sample bits 23 to 16 are ignored.
- R7: Slot 28 (validity) and slot 29 (user) are 0. Slot 31 makes the count of ones in slots 4 to 31 even.
- R8: Slot 30 of both subframes of frame n of a block carries channel-status bit n. Only bits 24 and 25 can be 1: `rate_sel`=2 (32 kHz) sets both, `rate_sel`=1 (48 kHz) sets bit 25 only, and `rate_sel`=0 or 3 (44.1 kHz) sets neither. `rate_sel` is sampled when each block begins.
- R9: If `s_valid` is low while `s_ready` is high, the next frame carries an all-zero audio word in both subframes and `consumed` does not change.
- R10: Each taken sample raises `take_pulse` for exactly the first cycle of its frame, and in that same cycle `consumed` has advanced by one, wrapping at its width.
- R11: The left word goes in the first subframe of a frame and the right word in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, two ticks per line bit |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | A stereo sample is offered |
| s_ready | output | 1 | High in the one cycle per frame when a sample is taken |
| s_left | input | 24 | Left sample, two's complement |
| s_right | input | 24 | Right sample, two's complement |
| use16 | input | 1 | Sample is 16 bits wide, held in bits 15:0 |
| rate_sel | input | 2 | Sample-rate code: 0 = 44.1 kHz, 1 = 48 kHz, 2 = 32 kHz, 3 = 44.1 kHz |
| line_out | output | 1 | Biphase-mark coded serial line |
| consumed | output | 16 | Running count of taken samples |
| take_pulse | output | 1 | One-cycle marker for each taken sample |

## Verification
The assertions check the line code on every cycle. Each data cell and each sync pattern must begin with a level change. The line must come back to its pre-sync level at the end of every subframe, which only holds when the parity and sync patterns agree. They also check that the take window opens once per frame and that the count moves only when a sample is taken. The bench alone can show that the coded line carries the right content: the values of the audio words, their placement in both widths, the sync kind at each block boundary, the channel-status sequence across a mid-block rate change, and silence on underrun. For that it decodes every captured frame back into slots and compares them with what it expects.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    localparam int AUDIO_W     = 24;
    localparam int NARROW_W    = 16;
    localparam int SLOTS       = 32;
    localparam int SYNC_SLOTS  = 4;
    localparam int FRAME_HALVES = SLOTS * 2 * 2;
    localparam int TICK_W      = $clog2(FRAME_HALVES);
    localparam int SLOT_W      = $clog2(SLOTS);

    typedef enum logic [1:0] {
        RATE_44K1 = 2'd0,
        RATE_48K  = 2'd1,
        RATE_32K  = 2'd2,
        RATE_RSVD = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        SYNC_BLOCK = 2'd0,
        SYNC_LEFT  = 2'd1,
        SYNC_RIGHT = 2'd2
    } sync_e;

    // position of one half-cell inside a frame; packs exactly into a tick
    typedef struct packed {
        logic              right;
        logic [SLOT_W-1:0] slot;
        logic              half;
    } cell_pos_t;

    typedef struct packed {
        logic [AUDIO_W-1:0] left;
        logic [AUDIO_W-1:0] right;
    } stereo_t;

    // half-cell levels for a line that stood low, first half-cell in bit 7
    function automatic logic [7:0] sync_pattern(sync_e kind);
        case (kind)
            SYNC_BLOCK: return 8'b1110_1000;
            SYNC_LEFT:  return 8'b1110_0010;
            default:    return 8'b1110_0100;
        endcase
    endfunction

    // channel-status bit for a frame index within the block
    function automatic logic status_bit(int unsigned idx, rate_e rate);
        if (idx == 24) return rate == RATE_32K;
        if (idx == 25) return (rate == RATE_48K) || (rate == RATE_32K);
        return 1'b0;
    endfunction

    // place a raw sample into the 24-bit audio word
    function automatic logic [AUDIO_W-1:0] place_word(logic [AUDIO_W-1:0] raw, logic narrow);
        if (narrow) return {raw[NARROW_W-1:0], {(AUDIO_W-NARROW_W){1'b0}}};
        return raw;
    endfunction

endpackage

// File: rtl/bmc_timing.sv
module bmc_timing
    import bmc_pkg::*;
#(
    parameter int BLOCK_LEN = 192
) (
    input  logic                         clk,
    input  logic                         rst,
    output cell_pos_t                    pos_q,
    output cell_pos_t                    pos_n,
    output logic [$clog2(BLOCK_LEN)-1:0] frame_n,
    output logic                         block_start_n,
    output logic                         load_win
);
    localparam int FRM_W = $clog2(BLOCK_LEN);
    localparam logic [TICK_W-1:0] LAST_TICK  = TICK_W'(FRAME_HALVES - 1);
    localparam logic [FRM_W-1:0]  LAST_FRAME = FRM_W'(BLOCK_LEN - 1);

    logic [TICK_W-1:0] tick_q;
    logic [TICK_W-1:0] tick_n;
    logic [FRM_W-1:0]  frame_q;
    logic              wrap;

    always_comb begin
        wrap    = (tick_q == LAST_TICK);
        tick_n  = wrap ? '0 : tick_q + 1'b1;
        frame_n = frame_q;
        if (wrap) frame_n = (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
        block_start_n = wrap && (frame_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= LAST_TICK;
            frame_q <= LAST_FRAME;
        end else begin
            tick_q  <= tick_n;
            frame_q <= frame_n;
        end
    end

    assign pos_q    = cell_pos_t'(tick_q);
    assign pos_n    = cell_pos_t'(tick_n);
    assign load_win = wrap;

    // R2
    take_once_chk: assert property (@(posedge clk) disable iff (rst)
        load_win |=> !load_win);

    // R8
    frame_bound_chk: assert property (@(posedge clk) disable iff (rst)
        frame_q <= LAST_FRAME);

endmodule

// File: rtl/bmc_frame_src.sv
module bmc_frame_src
    import bmc_pkg::*;
#(
    parameter int BLOCK_LEN = 192,
    parameter int CNT_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_win,
    input  logic                         block_start_n,
    input  cell_pos_t                    pos_n,
    input  logic [$clog2(BLOCK_LEN)-1:0] frame_n,
    input  logic                         s_valid,
    input  logic [AUDIO_W-1:0]           s_left,
    input  logic [AUDIO_W-1:0]           s_right,
    input  logic                         use16,
    input  logic [1:0]                   rate_sel,
    output logic                         cell_bit,
    output logic [CNT_W-1:0]             consumed,
    output logic                         take_pulse
);
    stereo_t            words_q;
    rate_e              rate_q;
    logic               accept;
    logic [AUDIO_W-1:0] word;
    logic               cs;
    logic               par;
    logic [SLOTS-1:0]   payload;

    assign accept = load_win && s_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q    <= '0;
            rate_q     <= RATE_44K1;
            consumed   <= '0;
            take_pulse <= 1'b0;
        end else begin
            take_pulse <= accept;
            if (accept) consumed <= consumed + 1'b1;
            if (load_win) begin
                if (accept) begin
                    words_q.left  <= place_word(s_left, use16);
                    words_q.right <= place_word(s_right, use16);
                end else begin
                    words_q <= '0;
                end
            end
            if (block_start_n) rate_q <= rate_e'(rate_sel);
        end
    end

    // slot layout: [31] parity, [30] status, [29] user, [28] validity,
    // [27:4] audio word LSB first, [3:0] sync (driven by the coder)
    always_comb begin
        word     = pos_n.right ? words_q.right : words_q.left;
        cs       = status_bit(int'(frame_n), rate_q);
        par      = ^{cs, word};
        payload  = {par, cs, 1'b0, 1'b0, word, {SYNC_SLOTS{1'b0}}};
        cell_bit = payload[pos_n.slot];
    end

    // R9
    silent_count_chk: assert property (@(posedge clk) disable iff (rst)
        (load_win && !s_valid) |=> $stable(consumed) && (words_q == '0));

    // R10
    pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> consumed == $past(consumed) + 1'b1);

endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder
    import bmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_pos_t pos_q,
    input  cell_pos_t pos_n,
    input  logic      first_frame_n,
    input  logic      cell_bit,
    output logic      line_q
);
    sync_e      kind;
    logic [7:0] pat;
    logic [2:0] pidx;
    logic       base;
    logic       lead_n;
    logic       nxt;
    logic       ref_q;

    always_comb begin
        if (pos_n.right)        kind = SYNC_RIGHT;
        else if (first_frame_n) kind = SYNC_BLOCK;
        else                    kind = SYNC_LEFT;
        pat    = sync_pattern(kind);
        pidx   = {pos_n.slot[1:0], pos_n.half};
        lead_n = (pos_n.slot == '0) && !pos_n.half;
        base   = lead_n ? line_q : ref_q;
        if (pos_n.slot < SLOT_W'(SYNC_SLOTS))
            nxt = pat[3'd7 - pidx] ^ base;
        else if (!pos_n.half)
            nxt = ~line_q;
        else
            nxt = line_q ^ cell_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            ref_q  <= 1'b0;
        end else begin
            line_q <= nxt;
            if (lead_n) ref_q <= line_q;
        end
    end

    // R3
    cell_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q.slot >= SLOT_W'(SYNC_SLOTS) && !pos_q.half) |-> line_q != $past(line_q));

    // R4
    sync_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q.slot == '0 && !pos_q.half) |-> line_q != $past(line_q));

    // R7
    level_return_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q.slot == SLOT_W'(SLOTS - 1) && pos_q.half) |-> line_q == ref_q);

endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
    import bmc_pkg::*;
#(
    parameter int BLOCK_LEN = 192,
    parameter int CNT_W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [AUDIO_W-1:0] s_left,
    input  logic [AUDIO_W-1:0] s_right,
    input  logic               use16,
    input  logic [1:0]         rate_sel,
    output logic               line_out,
    output logic [CNT_W-1:0]   consumed,
    output logic               take_pulse
);
    localparam int FRM_W = $clog2(BLOCK_LEN);

    cell_pos_t        pos_q;
    cell_pos_t        pos_n;
    logic [FRM_W-1:0] frame_n;
    logic             block_start_n;
    logic             load_win;
    logic             cell_bit;
    logic             first_frame_n;

    bmc_timing #(.BLOCK_LEN(BLOCK_LEN)) u_timing (
        .clk           (clk),
        .rst           (rst),
        .pos_q         (pos_q),
        .pos_n         (pos_n),
        .frame_n       (frame_n),
        .block_start_n (block_start_n),
        .load_win      (load_win)
    );

    bmc_frame_src #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)) u_src (
        .clk           (clk),
        .rst           (rst),
        .load_win      (load_win),
        .block_start_n (block_start_n),
        .pos_n         (pos_n),
        .frame_n       (frame_n),
        .s_valid       (s_valid),
        .s_left        (s_left),
        .s_right       (s_right),
        .use16         (use16),
        .rate_sel      (rate_sel),
        .cell_bit      (cell_bit),
        .consumed      (consumed),
        .take_pulse    (take_pulse)
    );

    assign first_frame_n = (frame_n == '0);

    bmc_line_coder u_coder (
        .clk           (clk),
        .rst           (rst),
        .pos_q         (pos_q),
        .pos_n         (pos_n),
        .first_frame_n (first_frame_n),
        .cell_bit      (cell_bit),
        .line_q        (line_out)
    );

    assign s_ready = load_win;

    // R1
    reset_level_chk: assert property (@(posedge clk)
        $past(rst) && rst |-> !line_out && consumed == '0 && !take_pulse);

endmodule

// File: tb/bmc_audio_tx_bench.sv
module bmc_audio_tx_bench;

    localparam int NFRAMES = 400;
    localparam int BLK     = 192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [23:0] s_left = '0;
    logic [23:0] s_right = '0;
    logic        use16 = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        line_out;
    logic [15:0] consumed;
    logic        take_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    bmc_audio_tx u_bmc_audio_tx (
        .clk        (clk),
        .rst        (rst),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .s_left     (s_left),
        .s_right    (s_right),
        .use16      (use16),
        .rate_sel   (rate_sel),
        .line_out   (line_out),
        .consumed   (consumed),
        .take_pulse (take_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(logic [23:0] raw, logic n16);
        logic [23:0] w;
        w = '0;
        if (n16) begin
            for (int k = 0; k < 16; k++) w[8+k] = raw[k];
        end else begin
            w = raw;
        end
        return w;
    endfunction

    function automatic logic exp_cs(int idx, logic [1:0] r);
        if (idx == 24) return r == 2'd2;
        if (idx == 25) return (r == 2'd1) || (r == 2'd2);
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_sync(int sub, int idx);
        if (sub == 1) return 8'b1110_0100;
        if (idx == 0) return 8'b1110_1000;
        return 8'b1110_0010;
    endfunction

    logic [127:0] cap;
    logic [23:0]  fr_l, fr_r;
    logic         fr_acc, fr_16;
    logic [1:0]   blk_rate;
    logic [15:0]  cnt_exp = '0;
    logic         prev_end = 1'b0;

    task automatic new_stimulus(input int f);
        case (f)
            0: begin s_valid = 1; s_left = 24'hFFFFFF; s_right = 24'h000000; use16 = 0; end
            1: begin s_valid = 1; s_left = 24'hAB1234; s_right = 24'hC0FFEE; use16 = 1; end
            2: begin s_valid = 0; s_left = 24'h123456; s_right = 24'h654321; use16 = 0; end
            3: begin s_valid = 1; s_left = 24'h800001; s_right = 24'h7FFFFE; use16 = 0; rate_sel = 2'd2; end
            default: begin
                s_valid = ($urandom % 5) != 0;
                s_left  = 24'($urandom);
                s_right = 24'($urandom);
                use16   = ($urandom % 3) == 0;
                if (($urandom % 40) == 0) rate_sel = 2'($urandom);
            end
        endcase
    endtask

    task automatic take_frame_start(input int f);
        chk(s_ready === 1'b1, "R2", "s_ready in last cycle", 32'(s_ready), 1);
        fr_acc = s_valid;
        fr_16  = use16;
        fr_l   = s_valid ? exp_word(s_left, use16) : 24'h0;
        fr_r   = s_valid ? exp_word(s_right, use16) : 24'h0;
        if ((f % BLK) == 0) blk_rate = rate_sel;
        if (s_valid) cnt_exp = cnt_exp + 1'b1;
    endtask

    task automatic decode_frame(input int f);
        int idx;
        idx = f % BLK;
        for (int sub = 0; sub < 2; sub++) begin
            int          b;
            logic        pv;
            logic [7:0]  pat;
            logic [31:0] dec;
            bit          sync_ok;
            bit          edge_ok;
            logic [23:0] ew;
            b   = sub * 64;
            pv  = (sub == 0) ? prev_end : cap[63];
            pat = exp_sync(sub, idx);
            sync_ok = 1;
            for (int k = 0; k < 8; k++)
                if (cap[b+k] !== (pat[7-k] ^ pv)) sync_ok = 0;
            chk(sync_ok, "R4", $sformatf("sync frame %0d sub %0d", f, sub),
                32'(cap[b +: 8]), 32'(pat));
            dec = '0;
            edge_ok = 1;
            for (int s = 4; s < 32; s++) begin
                logic a, h, p;
                a = cap[b+2*s];
                h = cap[b+2*s+1];
                p = cap[b+2*s-1];
                if (a === p) edge_ok = 0;
                dec[s] = a ^ h;
            end
            chk(edge_ok, "R3", $sformatf("cell-start transitions frame %0d sub %0d", f, sub), 0, 0);
            ew = (sub == 0) ? fr_l : fr_r;
            if (!fr_acc)
                chk(dec[27:4] === ew, "R9", $sformatf("underrun word frame %0d", f), 32'(dec[27:4]), 32'(ew));
            else if (fr_16)
                chk(dec[27:4] === ew, "R6", $sformatf("narrow word frame %0d sub %0d", f, sub), 32'(dec[27:4]), 32'(ew));
            else
                chk(dec[27:4] === ew, "R5/R11", $sformatf("wide word frame %0d sub %0d", f, sub), 32'(dec[27:4]), 32'(ew));
            chk(dec[29:28] === 2'b00, "R7", "validity/user", 32'(dec[29:28]), 0);
            chk((^dec[31:4]) === 1'b0, "R7", "even parity", 32'(dec[31:4]), 0);
            chk(dec[30] === exp_cs(idx, blk_rate), "R8",
                $sformatf("status bit %0d", idx), 32'(dec[30]), 32'(exp_cs(idx, blk_rate)));
        end
        prev_end = cap[127];
    endtask

    initial begin
        void'($urandom(32'd2024));
        new_stimulus(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk(line_out === 1'b0, "R1", "line in reset", 32'(line_out), 0);
        chk(consumed === 16'd0, "R1", "count in reset", 32'(consumed), 0);
        chk(take_pulse === 1'b0, "R1", "pulse in reset", 32'(take_pulse), 0);
        rst = 1'b0;
        take_frame_start(0);
        for (int f = 0; f < NFRAMES; f++) begin
            bit ready_ok;
            ready_ok = 1;
            for (int h = 0; h < 128; h++) begin
                @(negedge clk);
                cap[h] = line_out;
                if (h < 127 && s_ready !== 1'b0) ready_ok = 0;
                if (h == 0) begin
                    // R10
                    chk(take_pulse === fr_acc, "R10", "pulse at frame start", 32'(take_pulse), 32'(fr_acc));
                    chk(consumed === cnt_exp, "R10", "consumed count", 32'(consumed), 32'(cnt_exp));
                end
                if (h == 1)
                    chk(take_pulse === 1'b0, "R10", "pulse one cycle", 32'(take_pulse), 0);
                if (h == 20) new_stimulus(f + 1);
            end
            chk(ready_ok, "R2", "s_ready low inside frame", 0, 0);
            decode_frame(f);
            if (f + 1 < NFRAMES) take_frame_start(f + 1);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule